// File: doc/BRIEF.md
# PLL Unlock Detector with Hold Extension

This block watches the phase-error pulse coming out of a phase/frequency comparator and drives an active-low unlock indicator. The phase-error pulse arrives as a digital level that is synchronous to a known system clock. A 2-bit mode field selects one of four behaviours:

- the detector is stopped and its output is released;
- the phase-error level is passed straight through;
- the width of each error pulse is compared with a narrow limit;
- the width of each error pulse is compared with a wide limit.

In the two comparing modes, a pulse wider than the limit pulls the indicator low. A hold timer then keeps it low for a fixed stretch of about 1.5 ms.

Pulse widths are measured in system-clock cycles. Both width limits and the hold length are derived from the clock frequency parameter `CLK_KHZ`:

- narrow limit = floor(CLK_KHZ*560/1e6) cycles;
- wide limit = floor(CLK_KHZ*1110/1e6) cycles;
- hold = CLK_KHZ*1500/1000 cycles.

The indicator pin models an open-drain driver. It is a data bit plus an output enable, where enable 0 means the pin is released. Every output is registered, so it reflects the inputs sampled at the previous clock edge.

Top module: `pll_unlock_detect`

## Requirements
- R1: Reset selects the stopped mode: `unlock_n_o` is 1 and `unlock_oe_o` is 0 until inputs are sampled after reset.
- R2: With `mode_i` = 2'b00 (stopped), after the next edge `unlock_oe_o` is 0 and `unlock_n_o` is 1, whatever `perr_i` does.
- R3: With `mode_i` = 2'b01 (pass-through), after each edge `unlock_oe_o` is 1 and `unlock_n_o` equals the inverse of `perr_i` sampled at that edge.
- R4: With `mode_i` = 2'b10, a pulse lasting more than the narrow limit in consecutive high cycles flags unlock, and a pulse of exactly the narrow limit does not.
- R5: With `mode_i` = 2'b11, the wide limit is used in the same way. A pulse of exactly the wide limit does not flag, and one cycle more does.
- R6: In the comparing modes, `unlock_n_o` goes to 0 at the edge that samples the first high cycle exceeding the limit. The output never falls unless `perr_i` was high at the edge before.
- R7: After the last over-limit cycle, `unlock_n_o` stays 0 for exactly the hold length in cycles, then returns to 1.
- R8: Every further over-limit cycle restarts the hold, so the output returns high only after a full hold length without a new violation.
- R9: A change of `mode_i` clears both the hold timer and the pulse-width count. In a comparing mode the output is 1 after that edge, and pulse width is counted afresh from the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for width measurement and hold timing |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode: 00 stopped, 01 pass-through, 10 narrow limit, 11 wide limit |
| perr_i | input | 1 | Phase-error pulse, high while a phase error is present |
| unlock_n_o | output | 1 | Unlock indicator, 0 = unlocked |
| unlock_oe_o | output | 1 | Output enable for the indicator pin, 0 = released (stopped mode) |

## Verification
The assertions take for granted that `perr_i` and `mode_i` are already synchronous to `clk_i`. They also assume that the hold length is at least one cycle and that the narrow limit does not exceed the wide one. The stimulus changes both inputs only on the falling clock edge. It uses a clock parameter small enough that each hold lasts 7500 cycles, with limits of 2 and 5 cycles, so pulse widths of exactly the limit and one more can be placed directly. Mode changes are applied both while the output is held low and in the middle of a pulse.

// File: rtl/ud_pkg.sv
package ud_pkg;
    typedef enum logic [1:0] {
        UD_STOP   = 2'b00,
        UD_PASS   = 2'b01,
        UD_NARROW = 2'b10,
        UD_WIDE   = 2'b11
    } ud_mode_e;
endpackage

// File: rtl/ud_width_meter.sv
module ud_width_meter #(
    parameter int NARROW_CYC = 70,
    parameter int WIDE_CYC   = 138
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic perr_i,
    input  logic wide_sel_i,
    output logic over_o
);
    localparam int SAT_CYC = ((WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC) + 1;
    localparam int CW      = $clog2(SAT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } meter_t;

    meter_t        st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d   = st_q;
        limit  = wide_sel_i ? CW'(WIDE_CYC) : CW'(NARROW_CYC);
        over_o = perr_i && !clear_i && (st_q.run >= limit);
        if (clear_i || !perr_i) begin
            st_d.run = '0;
        end else if (st_q.run != CW'(SAT_CYC)) begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    over_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        over_o && (limit != '0) |-> $past(perr_i));

    // R9
    clear_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clear_i) |-> !over_o || (limit == '0));
endmodule

// File: rtl/ud_hold_timer.sv
module ud_hold_timer #(
    parameter int EXT_CYC = 187500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic load_i,
    output logic busy_o
);
    localparam int TW = $clog2(EXT_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] left;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.left = '0;
        end else if (load_i) begin
            st_d.left = TW'(EXT_CYC);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    assign busy_o = (st_q.left != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    hold_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(load_i));

    // R8
    hold_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && !clear_i |=> busy_o);

    // R7
    hold_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> !$past(load_i));
endmodule

// File: rtl/ud_out_stage.sv
module ud_out_stage
    import ud_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  ud_mode_e mode_i,
    input  logic     perr_i,
    input  logic     hold_busy_i,
    output ud_mode_e mode_q_o,
    output logic     unlock_n_o,
    output logic     oe_o
);
    typedef struct packed {
        ud_mode_e mode;
        logic     pass_n;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d.mode   = mode_i;
        st_d.pass_n = !perr_i;
        unique case (st_q.mode)
            UD_STOP: unlock_n_o = 1'b1;
            UD_PASS: unlock_n_o = st_q.pass_n;
            default: unlock_n_o = !hold_busy_i;
        endcase
        oe_o = (st_q.mode != UD_STOP);
    end

    assign mode_q_o = st_q.mode;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: UD_STOP, pass_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pll_unlock_detect.sv
module pll_unlock_detect
    import ud_pkg::*;
#(
    parameter int CLK_KHZ   = 125000,
    parameter int NARROW_NS = 560,
    parameter int WIDE_NS   = 1110,
    parameter int HOLD_US   = 1500
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       perr_i,
    output logic       unlock_n_o,
    output logic       unlock_oe_o
);
    localparam int NARROW_CYC = CLK_KHZ * NARROW_NS / 1000000;
    localparam int WIDE_CYC   = CLK_KHZ * WIDE_NS / 1000000;
    localparam int EXT_CYC    = CLK_KHZ * HOLD_US / 1000;

    typedef struct packed {
        logic changed;
        logic meter_clr;
        logic hold_clr;
        logic hold_load;
    } ctrl_t;

    ud_mode_e mode_in, mode_q;
    ctrl_t    ctl_d;
    logic     over, hold_busy;

    assign mode_in = ud_mode_e'(mode_i);

    always_comb begin
        ctl_d.changed   = (mode_in != mode_q);
        ctl_d.meter_clr = ctl_d.changed || (mode_in == UD_STOP);
        ctl_d.hold_clr  = ctl_d.changed || !mode_in[1];
        ctl_d.hold_load = over && mode_in[1];
    end

    ud_width_meter #(
        .NARROW_CYC(NARROW_CYC),
        .WIDE_CYC  (WIDE_CYC)
    ) u_meter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (ctl_d.meter_clr),
        .perr_i    (perr_i),
        .wide_sel_i(mode_in[0]),
        .over_o    (over)
    );

    ud_hold_timer #(
        .EXT_CYC(EXT_CYC)
    ) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(ctl_d.hold_clr),
        .load_i (ctl_d.hold_load),
        .busy_o (hold_busy)
    );

    ud_out_stage u_out (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode_in),
        .perr_i     (perr_i),
        .hold_busy_i(hold_busy),
        .mode_q_o   (mode_q),
        .unlock_n_o (unlock_n_o),
        .oe_o       (unlock_oe_o)
    );

    // R2
    stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_i) == 2'b00 |-> unlock_n_o && !unlock_oe_o);

    // R3
    pass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && ($past(mode_i) == 2'b01) |->
            unlock_oe_o && (unlock_n_o == !$past(perr_i)));

    // R6
    fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(unlock_n_o) |-> $past(perr_i));

    // R9
    switch_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && mode_i[1] && (mode_i != $past(mode_i)) |=> unlock_n_o);
endmodule

// File: tb/tb_pll_unlock_detect.sv
module tb_pll_unlock_detect;
    localparam int CLK_KHZ = 5000;
    localparam int NARROW  = CLK_KHZ * 560 / 1000000;
    localparam int WIDE    = CLK_KHZ * 1110 / 1000000;
    localparam int EXT     = CLK_KHZ * 1500 / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       perr = 1'b0;
    logic       unlock_n, unlock_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_prev = 0;
    int m_run = 0;
    int m_hold = 0;
    bit exp_n = 1'b1;
    bit exp_oe = 1'b0;

    always #4 clk = ~clk;

    pll_unlock_detect #(.CLK_KHZ(CLK_KHZ)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .perr_i     (perr),
        .unlock_n_o (unlock_n),
        .unlock_oe_o(unlock_oe)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic advance(int m, bit p);
        int  th;
        bit  chg;
        bit  viol;
        chg  = (m != m_prev);
        th   = (m == 3) ? WIDE : NARROW;
        viol = (m >= 2) && !chg && p && (m_run >= th);
        if (chg || m == 0 || !p) m_run = 0;
        else m_run++;
        if (chg || m < 2) m_hold = 0;
        else if (viol) m_hold = EXT;
        else if (m_hold > 0) m_hold--;
        exp_oe = (m != 0);
        exp_n  = (m == 0) ? 1'b1 : (m == 1) ? !p : (m_hold == 0);
        m_prev = m;
    endtask

    task automatic step(string tag, int m, bit p);
        @(negedge clk);
        check(tag, "unlock_n", unlock_n, exp_n);
        check(tag, "unlock_oe", unlock_oe, exp_oe);
        mode = 2'(m);
        perr = p;
        advance(m, p);
    endtask

    task automatic pulse(string tag, int m, int width, int gap);
        for (int i = 0; i < width; i++) step(tag, m, 1'b1);
        for (int i = 0; i < gap; i++) step(tag, m, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "unlock_n", unlock_n, 1'b1);
        check("R1", "unlock_oe", unlock_oe, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R1", 0, 1'b0);
        // R2: stopped mode ignores error pulses
        pulse("R2", 0, 10, 3);
        pulse("R2", 0, 1, 2);
        // R3: pass-through of the raw level
        pulse("R3", 1, 1, 1);
        pulse("R3", 1, 3, 2);
        pulse("R3", 1, 12, 4);
        // R4: narrow limit, width equal to the limit does not flag
        pulse("R4", 2, NARROW, 20);
        // R6 / R7: one cycle over the limit, then a full hold
        pulse("R6", 2, NARROW + 1, 0);
        pulse("R7", 2, 0, EXT + 20);
        // R8: retrigger within the hold
        pulse("R8", 2, NARROW + 1, 4000);
        pulse("R8", 2, NARROW + 2, EXT + 20);
        // R5: wide limit boundary
        pulse("R5", 3, WIDE, 20);
        pulse("R5", 3, WIDE + 1, 50);
        // R9: mode change during the hold releases the output
        pulse("R9", 2, 0, 20);
        // R9: mode change in the middle of a pulse restarts the width count
        pulse("R9", 2, NARROW, 0);
        pulse("R9", 3, WIDE, 20);
        // R2 after a held unlock in a comparing mode
        pulse("R2", 3, WIDE + 3, 30);
        pulse("R2", 0, 6, 10);
        // R3 directly after a held unlock
        pulse("R7", 2, NARROW + 1, 10);
        pulse("R3", 1, 2, 3);
        pulse("R3", 1, 1, 5);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule